// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a single-cycle processor and computes its next value every clock cycle. The current count drives the instruction memory address. An incremented copy, which is the count plus one instruction word (4), is brought out for observation. The register has no load enable, so it takes a new value on every rising edge.

The next value is either the sequential address (count + 4) or a branch target. The branch target is the sequential address plus the instruction's 16-bit immediate, sign-extended to the address width and scaled to a word offset (shifted left by two). The branch target is used only when the datapath asserts its branch select and the ALU reports a zero result, which means the two compared registers are equal. All address arithmetic wraps modulo 2^32. A synchronous active-high reset loads a parameterised reset vector, which is 0 by default.

Top module: `pc_next_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_o` equals the reset vector (0 by default) after that edge, whatever the other inputs are.
- R2: When `rst` is low and `br_sel_i` is 0, the next `pc_o` is the current `pc_o` + 4, whatever the values of `alu_zero_i` and `imm_i`.
- R3: When `br_sel_i` is 1 and `alu_zero_i` is 0, the next `pc_o` is the current `pc_o` + 4, and the immediate has no effect.
- R4: When `br_sel_i` is 1 and `alu_zero_i` is 1, the next `pc_o` is `pc_o` + 4 + (`imm_i` sign-extended from bit 15 into bits 31:16, then shifted left by two).
- R5: All address arithmetic wraps modulo 2^32. A negative `imm_i` (bit 15 set) gives a lower address. Stepping past 0xFFFFFFFC wraps to 0x00000000.
- R6: `pc_plus4_o` always equals `pc_o` + 4 (mod 2^32) in the same cycle.
- R7: Bits 1:0 of `pc_o` are 0 after reset and stay 0 through every update.
- R8: The count changes on every rising edge outside reset. There is no hold or enable, so N consecutive sequential cycles advance `pc_o` by 4·N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| br_sel_i | input | 1 | Current instruction is a conditional branch |
| alu_zero_i | input | 1 | ALU result is zero (compared registers are equal) |
| imm_i | input | 16 | Immediate field of the current instruction (word offset) |
| pc_o | output | 32 | Current program counter (instruction address) |
| pc_plus4_o | output | 32 | Current program counter + 4 |

## Verification
`pc_o` is registered. A select, flag or immediate applied in one cycle therefore shows up in `pc_o` exactly one rising edge later, and a reset takes effect on that same edge. `pc_plus4_o` is combinational from `pc_o`, so it is due in the same cycle. The bench changes inputs on the falling edge, lets one rising edge pass, and samples both outputs on the next falling edge. It compares them with a bench model that advances by one step per edge.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;

    // Source of the next program counter value
    typedef enum logic {
        NXT_SEQ    = 1'b0,
        NXT_BRANCH = 1'b1
    } nxt_src_e;

endpackage

// File: rtl/pc_step_add.sv
// Sequential-address adder: current count plus one instruction word.
module pc_step_add #(
    parameter int ADDR_W   = 32,
    parameter int ALIGN_SH = 2
) (
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] seq_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_SH;

    always_comb begin
        seq_o = pc_i + STEP;
    end
endmodule

// File: rtl/pc_branch_target.sv
// Branch target: sequential address plus scaled, sign-extended offset.
module pc_branch_target #(
    parameter int ADDR_W   = 32,
    parameter int IMM_W    = 16,
    parameter int ALIGN_SH = 2
) (
    input  logic [ADDR_W-1:0] seq_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] ext_imm;
    logic [ADDR_W-1:0] off_scaled;

    always_comb begin
        ext_imm = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end

    generate
        if (ALIGN_SH > 0) begin : g_scale
            always_comb begin
                off_scaled = {ext_imm[ADDR_W-ALIGN_SH-1:0], {ALIGN_SH{1'b0}}};
            end
        end else begin : g_noscale
            always_comb begin
                off_scaled = ext_imm;
            end
        end
    endgenerate

    always_comb begin
        tgt_o = seq_i + off_scaled;
    end
endmodule

// File: rtl/pc_next_sel.sv
// Decides taken/not taken and selects the next address.
module pc_next_sel
    import pc_next_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              br_sel_i,
    input  logic              zero_i,
    input  logic [ADDR_W-1:0] seq_i,
    input  logic [ADDR_W-1:0] tgt_i,
    output logic [ADDR_W-1:0] next_o
);
    nxt_src_e src;

    always_comb begin
        src = (br_sel_i && zero_i) ? NXT_BRANCH : NXT_SEQ;
        case (src)
            NXT_BRANCH: next_o = tgt_i;
            default:    next_o = seq_i;
        endcase
    end
endmodule

// File: rtl/pc_next_unit.sv
// Program counter register with next-address generation.
module pc_next_unit #(
    parameter int                 ADDR_W    = 32,
    parameter int                 IMM_W     = 16,
    parameter int                 ALIGN_SH  = 2,
    parameter logic [ADDR_W-1:0]  RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_sel_i,
    input  logic              alu_zero_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_plus4_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN_SH;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } regs_t;

    regs_t             r_d;
    regs_t             r_q;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] next_addr;

    pc_step_add #(
        .ADDR_W   (ADDR_W),
        .ALIGN_SH (ALIGN_SH)
    ) u_step (
        .pc_i  (r_q.pc),
        .seq_o (seq_addr)
    );

    pc_branch_target #(
        .ADDR_W   (ADDR_W),
        .IMM_W    (IMM_W),
        .ALIGN_SH (ALIGN_SH)
    ) u_tgt (
        .seq_i (seq_addr),
        .imm_i (imm_i),
        .tgt_o (br_addr)
    );

    pc_next_sel #(
        .ADDR_W (ADDR_W)
    ) u_sel (
        .br_sel_i (br_sel_i),
        .zero_i   (alu_zero_i),
        .seq_i    (seq_addr),
        .tgt_i    (br_addr),
        .next_o   (next_addr)
    );

    always_comb begin
        r_d    = r_q;
        r_d.pc = rst ? RESET_VEC : next_addr;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign pc_o       = r_q.pc;
    assign pc_plus4_o = seq_addr;

    // ---------------- assertions ----------------
    assert_reset_vec_R1: assert property (@(posedge clk)
        rst |=> (pc_o == RESET_VEC));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        !br_sel_i |=> (pc_o == $past(pc_o) + STEP));

    assert_not_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (br_sel_i && !alu_zero_i) |=> (pc_o == $past(pc_o) + STEP));

    assert_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (br_sel_i && alu_zero_i) |=>
        (pc_o == $past(pc_o) + STEP + (ADDR_W'($signed($past(imm_i))) << ALIGN_SH)));

    assert_incr_out_R6: assert property (@(posedge clk) disable iff (rst)
        pc_plus4_o == pc_o + STEP);

    assert_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        pc_o[ALIGN_SH-1:0] == '0);
endmodule

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_sel_i = 1'b0;
    logic        alu_zero_i = 1'b0;
    logic [15:0] imm_i = '0;
    logic [31:0] pc_o;
    logic [31:0] pc_plus4_o;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] exp_pc = '0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_next_unit u0 (
        .clk        (clk),
        .rst        (rst),
        .br_sel_i   (br_sel_i),
        .alu_zero_i (alu_zero_i),
        .imm_i      (imm_i),
        .pc_o       (pc_o),
        .pc_plus4_o (pc_plus4_o)
    );

    function automatic logic [31:0] model_next(input logic [31:0] pc, input logic br,
                                               input logic z, input logic [15:0] imm);
        logic [31:0] off;
        off = {{14{imm[15]}}, imm, 2'b00};
        if (br && z) return pc + 32'd4 + off;
        return pc + 32'd4;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge: drive, pass one rising edge, sample at next falling edge
    task automatic step(input string req, input logic br, input logic z, input logic [15:0] imm);
        br_sel_i   = br;
        alu_zero_i = z;
        imm_i      = imm;
        exp_pc     = model_next(exp_pc, br, z, imm);
        @(posedge clk);
        @(negedge clk);
        check(req, pc_o, exp_pc);
        check("R6", pc_plus4_o, exp_pc + 32'd4);
        check("R7", {30'd0, pc_o[1:0]}, 32'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        br_sel_i = 1'b1; alu_zero_i = 1'b1; imm_i = 16'h0123;
        repeat (2) @(posedge clk);
        @(negedge clk);
        exp_pc = '0;
        check("R1", pc_o, 32'd0);
        check("R6", pc_plus4_o, 32'd4);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R8 / R2: consecutive sequential steps, zero flag and immediate irrelevant
        for (int i = 0; i < 5; i++) step("R8", 1'b0, 1'b0, 16'h0000);
        check("R8", pc_o, 32'd20);
        step("R2", 1'b0, 1'b1, 16'h7FFF);
        step("R2", 1'b0, 1'b1, 16'h8000);

        // R3: branch select without equality
        step("R3", 1'b1, 1'b0, 16'h0010);
        step("R3", 1'b1, 1'b0, 16'hFFFF);

        // R4: forward taken branches
        step("R4", 1'b1, 1'b1, 16'h0003);
        step("R4", 1'b1, 1'b1, 16'h7FFF);

        // R5: backward branch to a lower address
        step("R5", 1'b1, 1'b1, 16'hFFFE);
        step("R5", 1'b1, 1'b1, 16'hFFFF);

        // R1: reset in mid-run
        do_reset();

        // R5: wrap below zero to the top, then past the top back to zero
        step("R5", 1'b1, 1'b1, 16'hFFFE);
        check("R5", pc_o, 32'hFFFF_FFFC);
        step("R5", 1'b0, 1'b0, 16'h0000);
        check("R5", pc_o, 32'h0000_0000);
        step("R5", 1'b1, 1'b1, 16'h8000);
        check("R5", pc_o, 32'hFFFE_0004);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic        br;
            logic        z;
            logic [15:0] imm;
            br  = ($urandom % 3) == 0;
            z   = $urandom[0];
            imm = 16'($urandom);
            step(br ? (z ? "R4" : "R3") : "R2", br, z, imm);
        end

        do_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule